// File: doc/BRIEF.md
# Supervisor Trap Entry Controller

This block tracks the current privilege level of a 64-bit core and owns the supervisor trap state. That state is the saved return PC, the trap cause, the trap value, the trap vector base, and three status bits: the interrupt enable, the previous enable and the previous mode. Each cycle it looks at four kinds of request: a synchronous exception request, which carries a code and a fault value; three interrupt pending lines (software, timer, external); a supervisor return request; and a small write port used to set up the state. It then decides which single event happens in that cycle.

When a trap is taken, the block saves the PC of the instruction and the status bits and raises the privilege level to supervisor. One cycle later it presents a redirect to the vector base. A return reverses the status handshake and redirects to the saved PC. Machine mode is the reset level. While the core is in machine mode this unit takes no traps; a return from machine mode moves the core to the level recorded in the previous-mode bit.

Top module: `strap_ctrl`

## Requirements
- R1: After reset the level is machine (encoding 2'b11). The enable, previous-enable and previous-mode bits are 0. The PC, cause, value, vector and interrupt-enable registers are 0, and redirect_valid is low.
- R2: An exception request in user (2'b00) or supervisor (2'b01) mode is taken. On the next cycle redirect_valid is 1, redirect_pc equals the vector base, the saved PC equals cur_pc, the cause equals the exception code with bit 63 clear, and the trap value equals exc_tval.
- R3: On any taken trap, the previous-enable bit gets the old enable bit, the enable bit is cleared, the previous-mode bit gets 1 if the old level was supervisor and 0 if it was user, and the level becomes supervisor.
- R4: An interrupt is taken only when all three hold: the enable bit is 1, the level is not machine, and some pending line has its enable bit set (ien bit 0 = software, bit 1 = timer, bit 2 = external). Otherwise the pending lines change nothing.
- R5: A taken interrupt sets cause bit 63 and writes code 1 for software, 5 for timer and 9 for external, and it writes 0 to the trap value.
- R6: An exception beats a simultaneous interrupt. Among interrupts, external wins over software, and software wins over timer.
- R7: A return in supervisor or machine mode does all of the following: enable gets previous-enable, the level becomes supervisor if previous-mode is 1 and user otherwise, previous-enable becomes 1, previous-mode becomes 0, and the next cycle redirects to the saved PC. A return in user mode is ignored.
- R8: In machine mode, exception requests and interrupts are ignored: no redirect and no change to any register.
- R9: A write (csr_sel 0 = vector, 1 = status with bit 0 enable / bit 1 previous-enable / bit 2 previous-mode, 2 = interrupt enables, 3 = saved PC) updates the selected register one cycle later. The two low bits of a vector write are forced to 0. A write in a cycle in which a trap or a return is taken is dropped.
- R10: A taken trap never leaves the level below the level it had before the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 64 | PC of the instruction at the commit point |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | 6 | Exception cause code |
| exc_tval | input | 64 | Faulting address or other exception information |
| irq_sw | input | 1 | Software interrupt pending |
| irq_tmr | input | 1 | Timer interrupt pending |
| irq_ext | input | 1 | External interrupt pending |
| ret_req | input | 1 | Supervisor return request |
| csr_we | input | 1 | State write strobe |
| csr_sel | input | 2 | State write select |
| csr_wdata | input | 64 | State write data |
| redirect_valid | output | 1 | Fetch redirect, one cycle after an event |
| redirect_pc | output | 64 | Redirect target |
| priv_o | output | 2 | Current privilege level |
| sie_o | output | 1 | Interrupt enable bit |
| spie_o | output | 1 | Previous interrupt enable bit |
| spp_o | output | 1 | Previous mode bit (1 = supervisor) |
| ien_o | output | 3 | Per-source interrupt enables |
| sepc_o | output | 64 | Saved PC |
| scause_o | output | 64 | Trap cause |
| stval_o | output | 64 | Trap value |
| stvec_o | output | 64 | Trap vector base |

## Verification
The assertions assume that the requesting pipeline holds every input steady across a clock edge. They also assume that at most one instruction commits per cycle, so that one exception, one return and a write can all point at the same cycle and the priority rules settle which one wins. The stimulus changes inputs only on the falling edge. It draws exception codes below 64 and full 64-bit PCs and values, and it mixes in returns in every mode, including user mode. This takes the core through user, supervisor and machine mode and covers both blocked and accepted interrupts.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_M = 2'b11
    } prv_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2,
        EV_RET  = 2'd3
    } ev_e;

    typedef enum logic [1:0] {
        SEL_VEC  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_EPC  = 2'd3
    } sel_e;

    localparam int IRQ_N  = 3;
    localparam int CODE_W = 4;
    localparam int SRC_SW  = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_EXT = 2;

    localparam logic [CODE_W-1:0] CODE_SW  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_TMR = 4'd5;
    localparam logic [CODE_W-1:0] CODE_EXT = 4'd9;

endpackage

// File: rtl/strap_irq_arb.sv
module strap_irq_arb
    import strap_pkg::*;
(
    input  logic [IRQ_N-1:0]  pend,
    input  logic [IRQ_N-1:0]  en,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    logic [IRQ_N-1:0] live;

    always_comb begin
        live = pend & en;
        any  = |live;
        code = '0;
        if (live[SRC_EXT]) begin
            code = CODE_EXT;
        end else if (live[SRC_SW]) begin
            code = CODE_SW;
        end else if (live[SRC_TMR]) begin
            code = CODE_TMR;
        end
    end

endmodule

// File: rtl/strap_event_sel.sv
module strap_event_sel
    import strap_pkg::*;
(
    input  logic exc_valid,
    input  logic irq_any,
    input  logic ret_req,
    input  logic sie,
    input  prv_e priv,
    output ev_e  ev
);
    logic below_m;

    always_comb begin
        below_m = (priv != PRV_M);
        ev      = EV_NONE;
        if (exc_valid && below_m) begin
            ev = EV_EXC;
        end else if (irq_any && sie && below_m) begin
            ev = EV_IRQ;
        end else if (ret_req && (priv != PRV_U)) begin
            ev = EV_RET;
        end
    end

endmodule

// File: rtl/strap_state.sv
module strap_state
    import strap_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int EXC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_e               ev,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [EXC_W-1:0]  exc_code,
    input  logic [XLEN-1:0]   exc_tval,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic              rv,
    output logic [XLEN-1:0]   rpc,
    output prv_e              priv,
    output logic              sie,
    output logic              spie,
    output logic              spp,
    output logic [IRQ_N-1:0]  ien,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   cause,
    output logic [XLEN-1:0]   tval,
    output logic [XLEN-1:0]   vec
);
    localparam int EXC_PAD = XLEN - 1 - EXC_W;
    localparam int IRQ_PAD = XLEN - 1 - CODE_W;
    localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(3));

    typedef struct packed {
        logic             rv;
        logic [XLEN-1:0]  rpc;
        prv_e             priv;
        logic             sie;
        logic             spie;
        logic             spp;
        logic [IRQ_N-1:0] ien;
        logic [XLEN-1:0]  epc;
        logic [XLEN-1:0]  cause;
        logic [XLEN-1:0]  tval;
        logic [XLEN-1:0]  vec;
    } st_t;

    st_t st_d, st_q;
    logic is_trap;

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        is_trap = (ev == EV_EXC) || (ev == EV_IRQ);
        if (is_trap) begin
            st_d.rv   = 1'b1;
            st_d.rpc  = st_q.vec;
            st_d.epc  = cur_pc;
            st_d.spie = st_q.sie;
            st_d.sie  = 1'b0;
            st_d.spp  = (st_q.priv == PRV_S);
            st_d.priv = PRV_S;
            if (ev == EV_EXC) begin
                st_d.cause = {1'b0, {EXC_PAD{1'b0}}, exc_code};
                st_d.tval  = exc_tval;
            end else begin
                st_d.cause = {1'b1, {IRQ_PAD{1'b0}}, irq_code};
                st_d.tval  = '0;
            end
        end else if (ev == EV_RET) begin
            st_d.rv   = 1'b1;
            st_d.rpc  = st_q.epc;
            st_d.sie  = st_q.spie;
            st_d.priv = st_q.spp ? PRV_S : PRV_U;
            st_d.spie = 1'b1;
            st_d.spp  = 1'b0;
        end else if (csr_we) begin
            case (sel_e'(csr_sel))
                SEL_VEC:  st_d.vec = csr_wdata & ALIGN_MASK;
                SEL_STAT: begin
                    st_d.sie  = csr_wdata[0];
                    st_d.spie = csr_wdata[1];
                    st_d.spp  = csr_wdata[2];
                end
                SEL_IEN:  st_d.ien = csr_wdata[IRQ_N-1:0];
                SEL_EPC:  st_d.epc = csr_wdata;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign rv    = st_q.rv;
    assign rpc   = st_q.rpc;
    assign priv  = st_q.priv;
    assign sie   = st_q.sie;
    assign spie  = st_q.spie;
    assign spp   = st_q.spp;
    assign ien   = st_q.ien;
    assign epc   = st_q.epc;
    assign cause = st_q.cause;
    assign tval  = st_q.tval;
    assign vec   = st_q.vec;

    AST_TRAP_ENTERS_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> (st_q.priv == PRV_S) && !st_q.sie && st_q.rv); // R3
    AST_SPIE_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> st_q.spie == $past(st_q.sie)); // R3
    AST_NO_PRIV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> st_q.priv >= $past(st_q.priv)); // R10
    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RET) |=> (st_q.sie == $past(st_q.spie)) && st_q.spie && !st_q.spp
                           && (st_q.rpc == $past(st_q.epc))); // R7
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE) |=> !st_q.rv && $stable(st_q.priv)); // R8

endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
    import strap_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int EXC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             exc_valid,
    input  logic [EXC_W-1:0] exc_code,
    input  logic [XLEN-1:0]  exc_tval,
    input  logic             irq_sw,
    input  logic             irq_tmr,
    input  logic             irq_ext,
    input  logic             ret_req,
    input  logic             csr_we,
    input  logic [1:0]       csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [1:0]       priv_o,
    output logic             sie_o,
    output logic             spie_o,
    output logic             spp_o,
    output logic [2:0]       ien_o,
    output logic [XLEN-1:0]  sepc_o,
    output logic [XLEN-1:0]  scause_o,
    output logic [XLEN-1:0]  stval_o,
    output logic [XLEN-1:0]  stvec_o
);
    logic [IRQ_N-1:0]  pend;
    logic [IRQ_N-1:0]  ien;
    logic              irq_any;
    logic [CODE_W-1:0] irq_code;
    logic              sie;
    prv_e              priv;
    ev_e               ev;

    always_comb begin
        pend          = '0;
        pend[SRC_SW]  = irq_sw;
        pend[SRC_TMR] = irq_tmr;
        pend[SRC_EXT] = irq_ext;
    end

    strap_irq_arb u_arb (
        .pend (pend),
        .en   (ien),
        .any  (irq_any),
        .code (irq_code)
    );

    strap_event_sel u_sel (
        .exc_valid (exc_valid),
        .irq_any   (irq_any),
        .ret_req   (ret_req),
        .sie       (sie),
        .priv      (priv),
        .ev        (ev)
    );

    strap_state #(.XLEN(XLEN), .EXC_W(EXC_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .cur_pc    (cur_pc),
        .exc_code  (exc_code),
        .exc_tval  (exc_tval),
        .irq_code  (irq_code),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .rv        (redirect_valid),
        .rpc       (redirect_pc),
        .priv      (priv),
        .sie       (sie),
        .spie      (spie_o),
        .spp       (spp_o),
        .ien       (ien),
        .epc       (sepc_o),
        .cause     (scause_o),
        .tval      (stval_o),
        .vec       (stvec_o)
    );

    assign priv_o = priv;
    assign sie_o  = sie;
    assign ien_o  = ien;

    AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && priv != PRV_M) |-> ev == EV_EXC); // R6
    AST_M_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRV_M) |-> (ev != EV_EXC) && (ev != EV_IRQ)); // R8
    AST_IRQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IRQ) |-> sie && ((pend & ien) != '0)); // R4
    AST_IRQ_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IRQ) |=> scause_o[XLEN-1] && (stval_o == '0)); // R5
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csr_we && csr_sel == 2'd0 && ev == EV_NONE) |-> stvec_o[1:0] == 2'b00); // R9

endmodule

// File: tb/tb_strap_ctrl.sv
module tb_strap_ctrl;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [63:0]     cur_pc = '0;
    logic            exc_valid = 1'b0;
    logic [5:0]      exc_code = '0;
    logic [63:0]     exc_tval = '0;
    logic            irq_sw = 1'b0, irq_tmr = 1'b0, irq_ext = 1'b0;
    logic            ret_req = 1'b0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_sel = '0;
    logic [63:0]     csr_wdata = '0;
    logic            redirect_valid;
    logic [63:0]     redirect_pc;
    logic [1:0]      priv_o;
    logic            sie_o, spie_o, spp_o;
    logic [2:0]      ien_o;
    logic [63:0]     sepc_o, scause_o, stval_o, stvec_o;

    strap_ctrl dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic        m_rv;
    logic [63:0] m_rpc, m_epc, m_cause, m_tval, m_vec;
    logic [1:0]  m_priv;
    logic        m_sie, m_spie, m_spp;
    logic [2:0]  m_ien;
    string       m_tag;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] irq_pick(input logic [2:0] live);
        if (live[2]) return 4'd9;
        if (live[0]) return 4'd1;
        if (live[1]) return 4'd5;
        return 4'd0;
    endfunction

    task automatic model_step();
        logic [2:0] live;
        logic below_m;
        live = {irq_ext, irq_tmr, irq_sw} & m_ien;
        below_m = (m_priv != 2'b11);
        m_rv = 1'b0;
        if (exc_valid && below_m) begin
            m_tag = "R2"; m_rv = 1'b1; m_rpc = m_vec; m_epc = cur_pc;
            m_cause = {58'd0, exc_code}; m_tval = exc_tval;
            m_spie = m_sie; m_sie = 1'b0; m_spp = (m_priv == 2'b01); m_priv = 2'b01;
        end else if ((live != 0) && m_sie && below_m) begin
            m_tag = "R5"; m_rv = 1'b1; m_rpc = m_vec; m_epc = cur_pc;
            m_cause = {1'b1, 59'd0, irq_pick(live)}; m_tval = '0;
            m_spie = m_sie; m_sie = 1'b0; m_spp = (m_priv == 2'b01); m_priv = 2'b01;
        end else if (ret_req && m_priv != 2'b00) begin
            m_tag = "R7"; m_rv = 1'b1; m_rpc = m_epc; m_sie = m_spie;
            m_priv = m_spp ? 2'b01 : 2'b00; m_spie = 1'b1; m_spp = 1'b0;
        end else if (csr_we) begin
            m_tag = "R9";
            case (csr_sel)
                2'd0: m_vec = csr_wdata & ~64'd3;
                2'd1: begin m_sie = csr_wdata[0]; m_spie = csr_wdata[1]; m_spp = csr_wdata[2]; end
                2'd2: m_ien = csr_wdata[2:0];
                default: m_epc = csr_wdata;
            endcase
        end else if (!below_m && (exc_valid || irq_sw || irq_tmr || irq_ext)) begin
            m_tag = "R8";
        end else begin
            m_tag = "R4";
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "redirect_valid", 64'(redirect_valid), 64'(m_rv));
        if (m_rv) chk(tag, "redirect_pc", redirect_pc, m_rpc);
        chk(tag, "priv", 64'(priv_o), 64'(m_priv));
        chk(tag, "status", 64'({spp_o, spie_o, sie_o}), 64'({m_spp, m_spie, m_sie}));
        chk(tag, "ien", 64'(ien_o), 64'(m_ien));
        chk(tag, "sepc", sepc_o, m_epc);
        chk(tag, "scause", scause_o, m_cause);
        chk(tag, "stval", stval_o, m_tval);
        chk(tag, "stvec", stvec_o, m_vec);
    endtask

    task automatic clear_in();
        exc_valid = 1'b0; irq_sw = 1'b0; irq_tmr = 1'b0; irq_ext = 1'b0;
        ret_req = 1'b0; csr_we = 1'b0;
    endtask

    // inputs already set at a falling edge; advance one cycle and compare
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(m_tag);
        clear_in();
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [63:0] d);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        cycle();
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_rv = 0; m_rpc = 0; m_epc = 0; m_cause = 0; m_tval = 0; m_vec = 0;
        m_priv = 2'b11; m_sie = 0; m_spie = 0; m_spp = 0; m_ien = 0; m_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // R8: machine mode ignores exceptions and interrupts
        exc_valid = 1'b1; exc_code = 6'd2; irq_ext = 1'b1; cur_pc = 64'h100;
        cycle();
        chk("R8", "no redirect in M", 64'(redirect_valid), 64'd0);

        // R9: vector alignment
        do_write(2'd0, 64'h8000_1003);
        chk("R9", "vector aligned", stvec_o, 64'h8000_1000);
        do_write(2'd2, 64'h7);
        // R7: return from M to S via previous-mode
        do_write(2'd1, 64'h6);
        csr_sel = 2'd3; csr_wdata = 64'h4000; cycle();
        csr_we = 1'b1; csr_sel = 2'd3; csr_wdata = 64'h8020_0000; cycle();
        ret_req = 1'b1; csr_we = 1'b1; csr_sel = 2'd0; csr_wdata = 64'hdead;
        cycle();
        chk("R7", "ret to S", 64'(priv_o), 64'd1);
        chk("R7", "ret target", redirect_pc, 64'h8020_0000);
        chk("R9", "write dropped on ret", stvec_o, 64'h8000_1000);

        // R2 / R3 / R6: exception with all interrupts pending
        exc_valid = 1'b1; exc_code = 6'd13; exc_tval = 64'hbad0; cur_pc = 64'h8020_0010;
        irq_sw = 1'b1; irq_tmr = 1'b1; irq_ext = 1'b1;
        cycle();
        chk("R6", "exception beats irq", scause_o, 64'd13);
        chk("R3", "spie from sie", 64'(spie_o), 64'd1);
        chk("R3", "spp from S", 64'(spp_o), 64'd1);
        chk("R10", "level not lowered", 64'(priv_o), 64'd1);

        // R4: interrupt blocked while enable bit clear
        irq_ext = 1'b1; cycle();
        chk("R4", "blocked irq", 64'(redirect_valid), 64'd0);

        // R6: external over software over timer
        do_write(2'd1, 64'h1);
        irq_sw = 1'b1; irq_tmr = 1'b1; irq_ext = 1'b1; cycle();
        chk("R6", "ext first", scause_o, {1'b1, 63'd9});
        do_write(2'd1, 64'h1);
        irq_sw = 1'b1; irq_tmr = 1'b1; cycle();
        chk("R6", "sw before tmr", scause_o, {1'b1, 63'd1});
        do_write(2'd1, 64'h1);
        irq_tmr = 1'b1; cycle();
        chk("R5", "timer code", scause_o, {1'b1, 63'd5});

        // R7: return in user mode is ignored
        do_write(2'd1, 64'h2);
        ret_req = 1'b1; cycle();
        chk("R7", "to user", 64'(priv_o), 64'd0);
        ret_req = 1'b1; cycle();
        chk("R7", "user ret ignored", 64'(redirect_valid), 64'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cur_pc = {$urandom, $urandom};
            exc_code = 6'($urandom);
            exc_tval = {$urandom, $urandom};
            exc_valid = (r < 12);
            ret_req = (r >= 12 && r < 28) || (r == 90);
            csr_we = (r >= 28 && r < 50) || (r == 91);
            csr_sel = 2'($urandom);
            csr_wdata = {$urandom, $urandom};
            irq_sw = ($urandom_range(0, 3) == 0);
            irq_tmr = ($urandom_range(0, 3) == 0);
            irq_ext = ($urandom_range(0, 5) == 0);
            cycle();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule